// File: doc/BRIEF.md
# Flash Command Sequence Controller

This block is the command front end of a parallel NOR flash model. The host drives a bus write by pulling chip enable and write enable low together; the controller decodes chains of these writes into operations. Two unlock writes followed by a command byte select either identification mode or a single program. Any write that does not fit the expected chain drops the controller back to plain array reads. Outside a command, reads return the stored array word.

In identification mode the low address byte selects the manufacturer code, the device code, or a per-sector protection flag. The controller stays in this mode until a reset command arrives. A program operation runs for a fixed number of cycles. During that time every read returns a status byte and every write is discarded. A program that tries to turn a 0 bit back into a 1 ends in a fault state. The fault state holds until a reset command is written. The array is a small behavioural memory in which programming can only clear bits.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset, `dout` is 0, the controller is in array-read mode, and every array cell reads FFFFh. A reset taken while in identification mode leaves that mode.
- R2: The write address is taken in the first cycle where `ce_n` and `we_n` are both low. The write data is the value seen in the last cycle where both are low. The write takes effect at the clock edge where either of them is first seen high again.
- R3: The writes AAh to 555h, 55h to 2AAh and 90h to 555h enter identification mode. In that mode, low address byte 00h reads the manufacturer code (0001h) and 01h reads the device code (2245h).
- R4: In identification mode, low address byte 02h (word mode) or 04h (byte mode) reads 0001h when the sector in the top two address bits is protected and 0000h when it is not. The default protection mask protects sectors 0 and 2.
- R5: Identification mode persists across reads and across writes whose low data byte is not F0h. A write of F0h to any address returns the controller to array reads.
- R6: A write whose address or data does not match the next expected unlock or command step returns the controller to array-read mode.
- R7: A write of F0h to any address between unlock writes cancels the sequence.
- R8: The writes AAh to 555h, 55h to 2AAh, A0h to 555h, then the target address and data start a program. The program lasts PROG_CYC (16) cycles. After it, the cell holds its old value ANDed with the data, and array reads resume on the next cycle.
- R9: While a program runs, each read returns a status word. Bit 7 is the complement of bit 7 of the program data. Bit 6 flips on every status read and starts at 0 after reset. All other bits are 0.
- R10: Writes during a program, including F0h, are ignored.
- R11: A program that would need any 0 bit to become 1 enters a fault state. In that state, status reads also set bit 5. Only a write of F0h returns the controller to array reads.
- R12: With `byte_mode` high, read data has its upper byte forced to 0 and a program writes only the low byte. The upper byte of the cell keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable; one read per cycle with `ce_n` low |
| byte_mode | input | 1 | 1 selects 8-bit data width |
| addr | input | 12 | Bus address |
| din | input | 16 | Write data |
| dout | output | 16 | Registered read data |

## Verification
A write changes the mode at the edge where its end is seen, which is the second edge after the write begins. A read is registered at the edge that samples `oe_n` low, so its result is taken at the following falling edge. The bench drives and samples only on falling edges, so every result is checked exactly one edge after the read that produced it. The program length is measured by placing a read on the sixteenth edge after the data write, which must return status, and another on the seventeenth, which must return the array word. The toggle bit is predicted by counting status reads in the bench.

// File: rtl/flash_cmd_pkg.sv
// Package: shared state type and bus command constants for the flash
// command controller. Assumes 16-bit data and at least 12 address bits.
package flash_cmd_pkg;
    typedef enum logic [2:0] {
        ST_READ, ST_UNLK1, ST_UNLK2, ST_IDENT, ST_PSETUP, ST_BUSY, ST_FAULT
    } fcmd_state_e;

    localparam int  UNLK_A1     = 'h555;
    localparam int  UNLK_A2     = 'h2AA;
    localparam logic [7:0] UNLK_D1  = 8'hAA;
    localparam logic [7:0] UNLK_D2  = 8'h55;
    localparam logic [7:0] CMD_RST  = 8'hF0;
    localparam logic [7:0] CMD_IDENT = 8'h90;
    localparam logic [7:0] CMD_PROG = 8'hA0;
endpackage

// File: rtl/flash_bus_capture.sv
// Bus capture: turns the asynchronous-style ce_n/we_n pair into one write
// strobe. Address is held from the cycle both go low, data tracks the bus
// while both are low, the strobe fires when either returns high.
// Assumes the bus pins are already synchronous to clk.
module flash_bus_capture #(
    parameter int AW = 12,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          we_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] din,
    output logic          wr_stb,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data
);
    logic act, act_q;

    assign act    = !ce_n && !we_n;
    assign wr_stb = act_q && !act;

    // Track the active window, freeze the address at its start, follow data inside it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            act_q <= act;
            if (act && !act_q) wr_addr <= addr;
            if (act)           wr_data <= din;
        end
    end
endmodule

// File: rtl/flash_cmd_fsm.sv
// Command state machine: walks unlock and command writes, holds the
// identification mode, runs the fixed-length program and flags a fault when
// a program would need a bit raised. Assumes old_word shows the target cell.
module flash_cmd_fsm
    import flash_cmd_pkg::*;
#(
    parameter int AW       = 12,
    parameter int DW       = 16,
    parameter int MEM_AW   = 6,
    parameter int PROG_CYC = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic              byte_mode,
    input  logic [DW-1:0]     old_word,
    output fcmd_state_e       st,
    output logic              pg_we,
    output logic [MEM_AW-1:0] pg_addr,
    output logic [DW-1:0]     pg_data
);
    localparam int CW = $clog2(PROG_CYC + 1);

    fcmd_state_e  nxt;
    logic [CW-1:0] cnt;
    logic [7:0]   cmd;
    logic         at_a1, at_a2, done;

    assign cmd   = wr_data[7:0];
    assign at_a1 = (wr_addr == AW'(UNLK_A1));
    assign at_a2 = (wr_addr == AW'(UNLK_A2));
    assign done  = (st == ST_BUSY) && (cnt == '0);
    assign pg_we = done;

    // Next-state decode for every write and for program completion.
    always_comb begin
        nxt = st;
        case (st)
            ST_READ:   if (wr_stb && at_a1 && cmd == UNLK_D1) nxt = ST_UNLK1;
            ST_UNLK1:  if (wr_stb) nxt = (at_a2 && cmd == UNLK_D2) ? ST_UNLK2 : ST_READ;
            ST_UNLK2:  if (wr_stb) begin
                           if (at_a1 && cmd == CMD_IDENT)     nxt = ST_IDENT;
                           else if (at_a1 && cmd == CMD_PROG) nxt = ST_PSETUP;
                           else                               nxt = ST_READ;
                       end
            ST_IDENT:  if (wr_stb && cmd == CMD_RST) nxt = ST_READ;
            ST_PSETUP: if (wr_stb) nxt = ST_BUSY;
            ST_BUSY:   if (cnt == '0)
                           nxt = ((old_word & pg_data) != pg_data) ? ST_FAULT : ST_READ;
            ST_FAULT:  if (wr_stb && cmd == CMD_RST) nxt = ST_READ;
            default:   nxt = ST_READ;
        endcase
    end

    // State register, program target latch and busy countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_READ;
            cnt     <= '0;
            pg_addr <= '0;
            pg_data <= '0;
        end else begin
            st <= nxt;
            if (st == ST_PSETUP && wr_stb) begin
                pg_addr <= wr_addr[MEM_AW-1:0];
                pg_data <= byte_mode ? {{(DW-8){1'b1}}, wr_data[7:0]} : wr_data;
                cnt     <= CW'(PROG_CYC - 1);
            end else if (st == ST_BUSY && cnt != '0) begin
                cnt <= cnt - 1'b1;
            end
        end
    end
endmodule

// File: rtl/flash_array.sv
// Behavioural array: erased to all ones at reset, programming ANDs data
// into a cell. One combinational port for bus reads, one for the program
// target. Assumes a small depth (a reset loop clears every cell).
module flash_array #(
    parameter int MEM_AW = 6,
    parameter int DW     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MEM_AW-1:0] rd_addr,
    output logic [DW-1:0]     rd_word,
    input  logic [MEM_AW-1:0] pg_addr,
    output logic [DW-1:0]     pg_old,
    input  logic              pg_we,
    input  logic [DW-1:0]     pg_data
);
    localparam int DEPTH = 1 << MEM_AW;

    logic [DW-1:0] mem [DEPTH];

    assign rd_word = mem[rd_addr];
    assign pg_old  = mem[pg_addr];

    // Erase on reset, clear bits on program completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
        end else if (pg_we) begin
            mem[pg_addr] <= mem[pg_addr] & pg_data;
        end
    end
endmodule

// File: rtl/flash_read_mux.sv
// Read path: picks array data, identification words or busy status by
// mode, masks the upper byte in byte mode, and registers the result once
// per read cycle. Owns the status toggle bit. Assumes NUM_SEC is a power of 2.
module flash_read_mux
    import flash_cmd_pkg::*;
#(
    parameter int          AW        = 12,
    parameter int          DW        = 16,
    parameter int          NUM_SEC   = 4,
    parameter logic [15:0] MFR_CODE  = 16'h0001,
    parameter logic [15:0] DEV_CODE  = 16'h2245,
    parameter logic [NUM_SEC-1:0] PROT_MASK = 4'b0101
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd,
    input  fcmd_state_e   st,
    input  logic [AW-1:0] addr,
    input  logic          byte_mode,
    input  logic [DW-1:0] arr_word,
    input  logic          pg_msb,
    output logic [DW-1:0] dout
);
    localparam int SEC_W = $clog2(NUM_SEC);

    logic          tgl, stat_mode;
    logic [DW-1:0] val, masked;
    logic [SEC_W-1:0] sec;

    assign sec       = addr[AW-1 -: SEC_W];
    assign stat_mode = (st == ST_BUSY) || (st == ST_FAULT);

    // Mode-dependent source select.
    always_comb begin
        val = arr_word;
        if (st == ST_IDENT) begin
            if (addr[7:0] == 8'h00)                           val = DW'(MFR_CODE);
            else if (addr[7:0] == 8'h01)                      val = DW'(DEV_CODE);
            else if (addr[7:0] == (byte_mode ? 8'h04 : 8'h02)) val = DW'(PROT_MASK[sec]);
            else                                              val = '0;
        end else if (stat_mode) begin
            val = DW'({~pg_msb, tgl, st == ST_FAULT, 5'b00000});
        end
        masked = byte_mode ? {{(DW-8){1'b0}}, val[7:0]} : val;
    end

    // Register read data and advance the toggle on each status read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout <= '0;
            tgl  <= 1'b0;
        end else if (rd) begin
            dout <= masked;
            if (stat_mode) tgl <= ~tgl;
        end
    end
endmodule

// File: rtl/flash_cmd_ctrl.sv
// Top: flash command sequence controller. Wires bus capture, command state
// machine, behavioural array and read path. Assumes all bus pins are
// sampled on clk and at most one access per cycle.
module flash_cmd_ctrl
    import flash_cmd_pkg::*;
#(
    parameter int AW        = 12,
    parameter int DW        = 16,
    parameter int MEM_AW    = 6,
    parameter int PROG_CYC  = 16,
    parameter int NUM_SEC   = 4,
    parameter logic [15:0] MFR_CODE  = 16'h0001,
    parameter logic [15:0] DEV_CODE  = 16'h2245,
    parameter logic [NUM_SEC-1:0] PROT_MASK = 4'b0101
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          we_n,
    input  logic          oe_n,
    input  logic          byte_mode,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);
    logic              wr_stb, rd, pg_we;
    logic [AW-1:0]     wr_addr;
    logic [DW-1:0]     wr_data, pg_data, pg_old, arr_word;
    logic [MEM_AW-1:0] pg_addr;
    fcmd_state_e       st;

    assign rd = !ce_n && !oe_n;

    flash_bus_capture #(.AW(AW), .DW(DW)) u_cap (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n),
        .addr(addr), .din(din),
        .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    flash_cmd_fsm #(.AW(AW), .DW(DW), .MEM_AW(MEM_AW), .PROG_CYC(PROG_CYC)) u_fsm (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
        .wr_data(wr_data), .byte_mode(byte_mode), .old_word(pg_old),
        .st(st), .pg_we(pg_we), .pg_addr(pg_addr), .pg_data(pg_data)
    );

    flash_array #(.MEM_AW(MEM_AW), .DW(DW)) u_arr (
        .clk(clk), .rst_n(rst_n), .rd_addr(addr[MEM_AW-1:0]), .rd_word(arr_word),
        .pg_addr(pg_addr), .pg_old(pg_old), .pg_we(pg_we), .pg_data(pg_data)
    );

    flash_read_mux #(
        .AW(AW), .DW(DW), .NUM_SEC(NUM_SEC),
        .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE), .PROT_MASK(PROT_MASK)
    ) u_rmux (
        .clk(clk), .rst_n(rst_n), .rd(rd), .st(st), .addr(addr),
        .byte_mode(byte_mode), .arr_word(arr_word), .pg_msb(pg_data[7]),
        .dout(dout)
    );
endmodule

// File: rtl/flash_cmd_chk.sv
// Checker: temporal properties of the command controller, attached to the
// top by bind. Observes the state, the write strobe and the read port.
module flash_cmd_chk
    import flash_cmd_pkg::*;
#(
    parameter int AW = 12,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input fcmd_state_e   st,
    input logic          wr_stb,
    input logic [AW-1:0] wr_addr,
    input logic [DW-1:0] wr_data,
    input logic          rd,
    input logic          byte_mode,
    input logic [DW-1:0] dout
);
    assert_reset_read_R1: assert property (@(posedge clk)
        !rst_n |=> (st == ST_READ));

    assert_ident_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDENT && !(wr_stb && wr_data[7:0] == CMD_RST)) |=> (st == ST_IDENT));

    assert_bad_unlock_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_UNLK1 && wr_stb && !(wr_addr == AW'(UNLK_A2) && wr_data[7:0] == UNLK_D2))
        |=> (st == ST_READ));

    assert_busy_no_cmd_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_BUSY) |=> (st == ST_BUSY || st == ST_READ || st == ST_FAULT));

    assert_fault_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FAULT && !(wr_stb && wr_data[7:0] == CMD_RST)) |=> (st == ST_FAULT));

    assert_byte_upper_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && byte_mode) |=> (dout[DW-1:8] == '0));
endmodule

bind flash_cmd_ctrl flash_cmd_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .st(st), .wr_stb(wr_stb), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd(rd), .byte_mode(byte_mode), .dout(dout)
);

// File: tb/flash_cmd_ctrl_test.sv
module flash_cmd_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, byte_mode = 1'b0;
    logic [11:0] addr = '0;
    logic [15:0] din = '0;
    logic [15:0] dout;
    int          checks = 0, fails = 0;
    logic        tgl_m = 1'b0;
    logic [15:0] got;

    flash_cmd_ctrl uut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .byte_mode(byte_mode), .addr(addr), .din(din), .dout(dout)
    );

    always #5 clk = ~clk;

    typedef struct packed {
        logic        rd;
        logic [11:0] a;
        logic [15:0] d;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 27;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 12'h010, 16'hFFFF, 4'd1},   // R1 erased read
        '{1'b0, 12'h555, 16'h00AA, 4'd3},   // R3 unlock
        '{1'b0, 12'h2AA, 16'h0055, 4'd3},
        '{1'b0, 12'h555, 16'h0090, 4'd3},
        '{1'b1, 12'h000, 16'h0001, 4'd3},   // R3 manufacturer
        '{1'b1, 12'h001, 16'h2245, 4'd3},   // R3 device
        '{1'b1, 12'h002, 16'h0001, 4'd4},   // R4 sector 0
        '{1'b1, 12'h402, 16'h0000, 4'd4},   // R4 sector 1
        '{1'b1, 12'h802, 16'h0001, 4'd4},   // R4 sector 2
        '{1'b1, 12'hC02, 16'h0000, 4'd4},   // R4 sector 3
        '{1'b0, 12'h123, 16'h0055, 4'd5},   // R5 non-reset write
        '{1'b1, 12'h001, 16'h2245, 4'd5},
        '{1'b0, 12'h777, 16'h00F0, 4'd5},   // R5 exit
        '{1'b1, 12'h001, 16'hFFFF, 4'd5},
        '{1'b0, 12'h555, 16'h00AA, 4'd6},   // R6 wrong data
        '{1'b0, 12'h2AA, 16'h0056, 4'd6},
        '{1'b0, 12'h555, 16'h0090, 4'd6},
        '{1'b1, 12'h001, 16'hFFFF, 4'd6},
        '{1'b0, 12'h555, 16'h00AA, 4'd7},   // R7 reset mid-unlock
        '{1'b0, 12'h3FF, 16'h00F0, 4'd7},
        '{1'b0, 12'h2AA, 16'h0055, 4'd7},
        '{1'b0, 12'h555, 16'h0090, 4'd7},
        '{1'b1, 12'h001, 16'hFFFF, 4'd7},
        '{1'b0, 12'h554, 16'h00AA, 4'd6},   // R6 wrong address
        '{1'b0, 12'h2AA, 16'h0055, 4'd6},
        '{1'b0, 12'h555, 16'h0090, 4'd6},
        '{1'b1, 12'h000, 16'hFFFF, 4'd6}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the falling edge after the commit edge.
    task automatic bus_wr(input logic [11:0] a, input logic [15:0] d);
        addr = a; din = d; ce_n = 1'b0; we_n = 1'b0;
        @(negedge clk);
        we_n = 1'b1; ce_n = 1'b1;
        @(negedge clk);
    endtask

    // Called at a falling edge; the result is registered at the next rising edge.
    task automatic bus_rd(input logic [11:0] a, output logic [15:0] q);
        addr = a; ce_n = 1'b0; oe_n = 1'b0;
        @(negedge clk);
        q = dout; oe_n = 1'b1; ce_n = 1'b1;
    endtask

    // Expected busy/fault status word; advances the toggle model.
    function automatic logic [15:0] stat(input logic d7, input logic flt);
        logic [15:0] s;
        s = {8'h00, ~d7, tgl_m, flt, 5'b0};
        tgl_m = ~tgl_m;
        return s;
    endfunction

    task automatic prog(input logic [11:0] a, input logic [15:0] d);
        bus_wr(12'h555, 16'h00AA);
        bus_wr(12'h2AA, 16'h0055);
        bus_wr(12'h555, 16'h00A0);
        bus_wr(a, d);
    endtask

    task automatic ident_enter();
        bus_wr(12'h555, 16'h00AA);
        bus_wr(12'h2AA, 16'h0055);
        bus_wr(12'h555, 16'h0090);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog all-requirements actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 dout after reset", dout, 16'h0000);

        // Vector table walk.
        for (int i = 0; i < NV; i++) begin
            if (VEC[i].rd) begin
                bus_rd(VEC[i].a, got);
                chk($sformatf("R%0d vector %0d", VEC[i].req, i), got, VEC[i].d);
            end else begin
                bus_wr(VEC[i].a, VEC[i].d);
            end
        end

        // R2: address from write start, data from write end.
        addr = 12'h555; din = 16'h0000; ce_n = 1'b0; we_n = 1'b1;
        @(negedge clk); we_n = 1'b0;
        @(negedge clk); addr = 12'h000; din = 16'h00AA;
        @(negedge clk); we_n = 1'b1;
        @(negedge clk); ce_n = 1'b1; addr = 12'h2AA; din = 16'h0000;
        @(negedge clk);
        bus_wr(12'h2AA, 16'h0055);
        bus_wr(12'h555, 16'h0090);
        bus_rd(12'h001, got);
        chk("R2 capture order", got, 16'h2245);
        bus_wr(12'h000, 16'h00F0);

        // R8 R9 R10: program and status reads.
        prog(12'h005, 16'h1234);
        bus_rd(12'h005, got); chk("R9 status first", got, stat(1'b0, 1'b0));
        bus_rd(12'h005, got); chk("R9 status toggled", got, stat(1'b0, 1'b0));
        bus_wr(12'h555, 16'h00F0);
        bus_rd(12'h005, got); chk("R10 reset ignored while busy", got, stat(1'b0, 1'b0));
        repeat (20) @(negedge clk);
        bus_rd(12'h005, got); chk("R8 programmed word", got, 16'h1234);

        // R8: exact busy length.
        prog(12'h007, 16'h00FF);
        repeat (15) @(negedge clk);
        bus_rd(12'h007, got); chk("R8 busy at last cycle", got, stat(1'b1, 1'b0));
        bus_rd(12'h007, got); chk("R8 array after busy", got, 16'h00FF);

        // R11: raising a bit faults; only reset exits.
        prog(12'h005, 16'hFFFF);
        repeat (20) @(negedge clk);
        bus_rd(12'h005, got); chk("R11 fault status", got, stat(1'b1, 1'b1));
        bus_wr(12'h555, 16'h00AA);
        bus_rd(12'h005, got); chk("R11 fault holds", got, stat(1'b1, 1'b1));
        bus_wr(12'h123, 16'h00F0);
        bus_rd(12'h005, got); chk("R11 exit to array", got, 16'h1234);

        // R12 and R4: byte mode.
        byte_mode = 1'b1;
        prog(12'h006, 16'hAB5A);
        repeat (20) @(negedge clk);
        bus_rd(12'h006, got); chk("R12 byte read", got, 16'h005A);
        byte_mode = 1'b0;
        bus_rd(12'h006, got); chk("R12 upper byte kept", got, 16'hFF5A);
        byte_mode = 1'b1;
        ident_enter();
        bus_rd(12'h804, got); chk("R4 byte offset protected", got, 16'h0001);
        bus_rd(12'h802, got); chk("R4 word offset in byte mode", got, 16'h0000);
        bus_rd(12'h001, got); chk("R12 device code masked", got, 16'h0045);
        bus_wr(12'h000, 16'h00F0);
        byte_mode = 1'b0;

        // R1: reset while in identification mode.
        ident_enter();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        bus_rd(12'h001, got); chk("R1 reset leaves ident", got, 16'hFFFF);
        bus_rd(12'h005, got); chk("R1 array erased", got, 16'hFFFF);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule